// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped, tagged store of branches that are expected to be taken. The fetch stage presents its current program counter on the lookup port each cycle. Within the same cycle the block returns a hit flag, a taken prediction and the next fetch address. On a hit this address is the recorded target. On a miss it is the sequential address PC+4.

When a branch resolves, the update port receives the branch address, the actual direction and the actual target. A taken branch installs or refreshes its entry and displaces whatever occupied that slot. A not-taken branch whose entry is present evicts it. A not-taken branch that is absent leaves the store alone. Branches that are not taken are never recorded, because they fetch the same way as ordinary instructions.

The low two PC bits are a byte offset within the word and play no part in indexing. The next IDX_W bits select the slot, and the remaining upper bits form the tag. Each slot holds a valid flag, the tag, the target and a 2-bit prediction state.

Top module: `btb`

## Requirements
- R1: After the asynchronous reset every slot is invalid, so every lookup reports lk_hit_o=0 and lk_next_pc_o=PC+4.
- R2: After an update with upd_valid_i=1 and upd_taken_i=1, a lookup of the same word address (PC bits above bit 1) reports lk_hit_o=1 and lk_next_pc_o equal to the supplied target.
- R3: A lookup that misses reports lk_hit_o=0, lk_taken_o=0 and lk_next_pc_o=PC+4, modulo 2^PC_W.
- R4: A lookup whose index bits (PC[IDX_W+1:2]) match a valid slot but whose tag bits (PC[PC_W-1:IDX_W+2]) differ misses.
- R5: A taken update to an occupied slot that carries a different tag replaces the occupant. The old branch then misses and the new branch hits.
- R6: A not-taken update whose word address matches a valid slot invalidates that slot, and lookups of that branch miss from the next cycle.
- R7: A not-taken update that misses, whether because of a tag mismatch or an empty slot, leaves the stored contents unchanged.
- R8: Lookup is combinational. An update made in a cycle becomes visible to lookups from the next cycle onward, and a same-cycle lookup sees the previous contents.
- R9: Install sets the prediction state to strongly taken (2'b11). lk_taken_o is 1 only on a hit whose state has bit 1 set, so after any install lk_taken_o equals lk_hit_o.
- R10: When upd_valid_i=0 the update inputs have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | PC_W | Fetch PC to look up |
| lk_hit_o | output | 1 | Valid slot with matching tag |
| lk_taken_o | output | 1 | Hit predicted taken |
| lk_next_pc_o | output | PC_W | Next fetch PC |
| upd_valid_i | input | 1 | Resolved branch present |
| upd_pc_i | input | PC_W | Resolved branch PC |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| upd_target_i | input | PC_W | Resolved target |

## Verification
A lookup and an update can fall in the same cycle on the same slot. The lookup must then return the contents as they stood before the write, and the change must appear in the following cycle. The bench provokes this collision with directed cases that install, overwrite and evict while the same PC is presented on the lookup port. A small tag pool in the random stream makes such collisions frequent. Each lookup is judged against a bench model that is updated only after the clock edge.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    PRED_STRONG_NT = 2'b00,
    PRED_WEAK_NT   = 2'b01,
    PRED_WEAK_T    = 2'b10,
    PRED_STRONG_T  = 2'b11
  } pred_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = pc_i[IDX_W+1:2];
  assign tag_o = pc_i[PC_W-1:IDX_W+2];
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic             ra_valid_o,
  output logic [TAG_W-1:0] ra_tag_o,
  output logic [PC_W-1:0]  ra_tgt_o,
  output pred_e            ra_state_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic             rb_valid_o,
  output logic [TAG_W-1:0] rb_tag_o
);
  logic             valid_q [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [PC_W-1:0]  tgt_q   [DEPTH];
  pred_e            state_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                valid_q[g] <= 1'b0;
      else if (sel && wr_en_i)    valid_q[g] <= 1'b1;
      else if (sel && clr_en_i)   valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (sel && wr_en_i) begin
        tag_q[g]   <= wr_tag_i;
        tgt_q[g]   <= wr_tgt_i;
        state_q[g] <= PRED_STRONG_T;
      end
    end
  end

  assign ra_valid_o = valid_q[ra_idx_i];
  assign ra_tag_o   = tag_q[ra_idx_i];
  assign ra_tgt_o   = tgt_q[ra_idx_i];
  assign ra_state_o = state_q[ra_idx_i];
  assign rb_valid_o = valid_q[rb_idx_i];
  assign rb_tag_o   = tag_q[rb_idx_i];
endmodule

// File: rtl/btb.sv
module btb
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic            lk_taken_o,
  output logic [PC_W-1:0] lk_next_pc_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             ra_valid, rb_valid;
  logic [TAG_W-1:0] ra_tag, rb_tag;
  logic [PC_W-1:0]  ra_tgt;
  pred_e            ra_state;
  logic             up_hit, wr_en, clr_en;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_split (
    .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag));
  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_split (
    .pc_i(upd_pc_i), .idx_o(up_idx), .tag_o(up_tag));

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .clr_en_i(clr_en),
    .wr_idx_i(up_idx), .wr_tag_i(up_tag), .wr_tgt_i(upd_target_i),
    .ra_idx_i(lk_idx), .ra_valid_o(ra_valid), .ra_tag_o(ra_tag),
    .ra_tgt_o(ra_tgt), .ra_state_o(ra_state),
    .rb_idx_i(up_idx), .rb_valid_o(rb_valid), .rb_tag_o(rb_tag));

  assign up_hit = rb_valid && (rb_tag == up_tag);
  assign wr_en  = upd_valid_i && upd_taken_i;
  // evict only the matching branch, never an alias
  assign clr_en = upd_valid_i && !upd_taken_i && up_hit;

  assign lk_hit_o     = ra_valid && (ra_tag == lk_tag);
  assign lk_taken_o   = lk_hit_o && ra_state[1];
  assign lk_next_pc_o = lk_taken_o ? ra_tgt : lk_pc_i + PC_W'(4);
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lk_pc_i,
  input logic            lk_hit_o,
  input logic            lk_taken_o,
  input logic [PC_W-1:0] lk_next_pc_o,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_target_i
);
  a_r2_install_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      (lk_pc_i[PC_W-1:2] != $past(upd_pc_i[PC_W-1:2])) ||
      (lk_hit_o && lk_next_pc_o == $past(upd_target_i)));

  a_r3_miss_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_next_pc_o == lk_pc_i + PC_W'(4)) && !lk_taken_o);

  a_r6_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |=>
      (lk_pc_i[PC_W-1:2] != $past(upd_pc_i[PC_W-1:2])) || !lk_hit_o);

  a_r9_taken_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_taken_o |-> lk_hit_o);
endmodule

bind btb btb_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_btb.sv
`timescale 1ns/1ps
module tb_btb;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk_i = 0;
  logic            rst_ni = 0;
  logic [PC_W-1:0] lk_pc_i = '0;
  logic            lk_hit_o, lk_taken_o;
  logic [PC_W-1:0] lk_next_pc_o;
  logic            upd_valid_i = 0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic            upd_taken_i = 0;
  logic [PC_W-1:0] upd_target_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic             m_valid [DEPTH];
  logic [TAG_W-1:0] m_tag   [DEPTH];
  logic [PC_W-1:0]  m_tgt   [DEPTH];

  always #5 clk_i = ~clk_i;

  btb #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (.*);

  function automatic logic m_hit(input logic [PC_W-1:0] pc);
    return m_valid[pc[IDX_W+1:2]] && m_tag[pc[IDX_W+1:2]] == pc[PC_W-1:IDX_W+2];
  endfunction

  function automatic logic [PC_W-1:0] m_next(input logic [PC_W-1:0] pc);
    return m_hit(pc) ? m_tgt[pc[IDX_W+1:2]] : pc + 4;
  endfunction

  function automatic logic [PC_W-1:0] mk_pc(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx), 2'b00};
  endfunction

  task automatic check(input string req);
    logic [PC_W-1:0] en = m_next(lk_pc_i);
    logic eh = m_hit(lk_pc_i);
    n_chk++;
    if (lk_hit_o !== eh || lk_taken_o !== eh || lk_next_pc_o !== en) begin
      n_fail++;
      $display("FAIL %s pc=%h hit/taken/next=%b/%b/%h exp %b/%b/%h", req, lk_pc_i,
               lk_hit_o, lk_taken_o, lk_next_pc_o, eh, eh, en);
    end
  endtask

  // one cycle: drive, check lookup pre-edge, then commit model
  task automatic step(input logic [PC_W-1:0] lpc, input logic uv, input logic [PC_W-1:0] upc,
                      input logic ut, input logic [PC_W-1:0] utgt, input string req);
    @(negedge clk_i);
    lk_pc_i = lpc; upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut; upd_target_i = utgt;
    #1 check(req);
    @(posedge clk_i);
    if (uv) begin
      if (ut) begin
        m_valid[upc[IDX_W+1:2]] = 1; m_tag[upc[IDX_W+1:2]] = upc[PC_W-1:IDX_W+2];
        m_tgt[upc[IDX_W+1:2]] = utgt;
      end else if (m_hit(upc)) m_valid[upc[IDX_W+1:2]] = 0;
    end
  endtask

  task automatic look(input logic [PC_W-1:0] lpc, input string req);
    step(lpc, 0, '0, 0, '0, req);
  endtask

  initial begin
    logic [PC_W-1:0] a, b;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
    #22 rst_ni = 1;
    for (int i = 0; i < 4; i++) look(mk_pc(i * 7, i * 3), "R1");
    look('1 - 3, "R3");  // wraps to zero
    a = mk_pc(5, 2); b = mk_pc(9, 2);
    step(a, 1, a, 1, 32'h0000_4000, "R8");  // same-cycle: old contents
    look(a, "R2");
    look(a | 32'h2, "R2");
    look(b, "R4");
    step(a, 1, b, 1, 32'h0000_8000, "R8");
    look(a, "R5");
    look(b, "R5");
    step(b, 1, a, 0, '0, "R7");
    look(b, "R7");
    step(b, 0, b, 0, '0, "R10");
    step(b, 0, a, 1, 32'h1234_5670, "R10");
    look(b, "R10");
    look(a, "R10");
    step(b, 1, b, 0, '0, "R8");
    look(b, "R6");
    step(b, 1, b, 0, '0, "R7");
    look(b, "R7");
    step(a, 1, a, 1, 32'h0000_0100, "R9");
    look(a, "R9");
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] lp = mk_pc($urandom_range(3), $urandom_range(DEPTH - 1));
      logic [PC_W-1:0] up = mk_pc($urandom_range(3), $urandom_range(DEPTH - 1));
      logic uv = ($urandom_range(3) != 0);
      step(lp, uv, up, $urandom_range(1) == 1, {$urandom, 2'b00} >> 2 << 2,
           m_hit(lp) ? "R2" : "R3");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule